// File: doc/BRIEF.md
# Multi-Checkpoint Self-Test Signature Controller

This block runs a built-in self-test session over a piece of logic. A 16-bit linear feedback shift register generates pseudo-random stimulus words on `pattern_o`. The logic under test returns a 16-bit response on `cut_resp_i`, and a multiple-input signature register folds that response into a running signature. The session is split into four windows of `WINDOW` cycles each. At the end of every window the signature is compared against one shared reference value. The signature register is never cleared between windows. The generator seed is chosen offline so that the running signature lands on that same reference at all four checkpoints.

A one-cycle pulse on `start_i` leaves the idle state. The session stops at the first checkpoint that mismatches, raises `fail_o` and `done_o`, and reports which checkpoint (1 to 4) failed on `fail_idx_o`. When all four checkpoints match, the controller raises `pass_o` and `done_o`. The result holds until the next reset. Because the comparison is always against the same constant, the compare logic costs what a single end-of-test check would cost. A faulty part is also rejected as early as its first bad window.

Top module: `bist_sig_ctrl`

## Requirements
- R1: After reset, `pattern_o` equals `SEED`, and `done_o`, `pass_o`, `fail_o` are 0 and `fail_idx_o` is 0. This state holds for as long as `start_i` stays low.
- R2: In every run cycle the pattern advances by the Galois step next = {p[14:0],0} XOR (p[15] ? 16'h6801 : 0). The step follows the polynomial x^16+x^14+x^13+x^11+1. The first run cycle presents `SEED`. The pattern holds in the idle, check, pass and fail states.
- R3: In every run cycle the signature becomes step(sig) XOR `cut_resp_i`, using the same Galois step. The signature starts at 0 after reset. It absorbs nothing during a check cycle and is not cleared between checkpoints.
- R4: A start pulse is followed by `WINDOW` run cycles and then one check cycle, repeated four times. Each window is therefore `WINDOW`+1 cycles.
- R5: Every checkpoint compares the signature against the single parameter `REF`.
- R6: On the first mismatching checkpoint k, the controller enters fail on the next edge. It sets `fail_o`=1 and `done_o`=1, with `fail_idx_o`=k (1 to 4), and no further patterns are generated.
- R7: When the fourth checkpoint matches, the controller enters pass on the next edge, with `pass_o`=1, `done_o`=1 and `fail_idx_o`=0.
- R8: `done_o`, `pass_o`, `fail_o` and `fail_idx_o` stay constant until reset. `start_i` is ignored everywhere except in idle.
- R9: `pass_o` and `fail_o` are never high together, and `fail_idx_o` is nonzero exactly when `fail_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled only in idle |
| cut_resp_i | input | 16 | Response word from the logic under test |
| pattern_o | output | 16 | Stimulus word to the logic under test |
| done_o | output | 1 | Session finished (pass or fail) |
| pass_o | output | 1 | All four checkpoints matched |
| fail_o | output | 1 | A checkpoint mismatched |
| fail_idx_o | output | 3 | Index 1..4 of the failing checkpoint, else 0 |

## Verification
The bench forces the signature onto the reference at every checkpoint by computing a corrective last response from its own signature model. It then flips one response bit in each window in turn. A controller with an off-by-one window length, or one that clears the signature between checkpoints, or one that absorbs responses during the check cycle, fails a good session at a checkpoint after the first. A misnumbered checkpoint counter reports the wrong index. A controller that keeps generating patterns or honours a late start after the verdict changes `pattern_o` or the flags in the cycles following the result. The bench also holds `start_i` high through a whole session to show that a long pulse does not restart or stretch the run.

// File: rtl/bist_pkg.sv
package bist_pkg;

    localparam int SIG_W = 16;
    // x^16 + x^14 + x^13 + x^11 + 1, Galois form feedback mask
    localparam logic [SIG_W-1:0] POLY_TAPS = 16'h6801;

    typedef logic [SIG_W-1:0] sig_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_CHECK,
        ST_PASS,
        ST_FAIL
    } st_e;

    function automatic sig_t galois_step(sig_t s);
        sig_t fb;
        fb = s[SIG_W-1] ? POLY_TAPS : '0;
        return {s[SIG_W-2:0], 1'b0} ^ fb;
    endfunction

endpackage

// File: rtl/bist_lfsr.sv
module bist_lfsr
    import bist_pkg::*;
#(
    parameter sig_t SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output sig_t pat
);
    sig_t s_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= SEED;
        end else if (adv) begin
            s_q <= galois_step(s_q);
        end
    end

    assign pat = s_q;
endmodule

// File: rtl/bist_misr.sv
module bist_misr
    import bist_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  sig_t din,
    output sig_t sig
);
    sig_t s_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else if (adv) begin
            s_q <= galois_step(s_q) ^ din;
        end
    end

    assign sig = s_q;
endmodule

// File: rtl/bist_win_timer.sv
module bist_win_timer #(
    parameter int WINDOW = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic last
);
    localparam int CNT_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WINDOW - 1);

    logic [CNT_W-1:0] cnt_q;

    assign last = en && (cnt_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bist_sig_ctrl.sv
module bist_sig_ctrl
    import bist_pkg::*;
#(
    parameter int   WINDOW = 1024,
    parameter int   CP_N   = 4,
    parameter sig_t SEED   = 16'hACE1,
    parameter sig_t REF    = 16'h5A3C
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [15:0] cut_resp_i,
    output logic [15:0] pattern_o,
    output logic        done_o,
    output logic        pass_o,
    output logic        fail_o,
    output logic [2:0]  fail_idx_o
);
    localparam int CP_W  = (CP_N > 2) ? $clog2(CP_N) : 1;
    localparam int IDX_W = 3;
    localparam logic [CP_W-1:0] CP_LAST = CP_W'(CP_N - 1);

    st_e              state_q;
    logic [CP_W-1:0]  cp_q;
    logic [IDX_W-1:0] idx_q;
    logic             running;
    logic             win_last;
    sig_t             sig;
    sig_t             pat;
    logic             sig_ok;

    assign running = (state_q == ST_RUN);

    bist_lfsr #(.SEED(SEED)) u_gen (
        .clk (clk),
        .rst (rst),
        .adv (running),
        .pat (pat)
    );

    bist_misr u_sig (
        .clk (clk),
        .rst (rst),
        .adv (running),
        .din (cut_resp_i),
        .sig (sig)
    );

    bist_win_timer #(.WINDOW(WINDOW)) u_win (
        .clk  (clk),
        .rst  (rst),
        .en   (running),
        .last (win_last)
    );

    // one comparator against a constant, shared by every checkpoint
    assign sig_ok = (sig == REF);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cp_q    <= '0;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start_i) state_q <= ST_RUN;
                ST_RUN:   if (win_last) state_q <= ST_CHECK;
                ST_CHECK: begin
                    if (!sig_ok) begin
                        state_q <= ST_FAIL;
                        idx_q   <= IDX_W'(cp_q) + 1'b1;
                    end else if (cp_q == CP_LAST) begin
                        state_q <= ST_PASS;
                    end else begin
                        cp_q    <= cp_q + 1'b1;
                        state_q <= ST_RUN;
                    end
                end
                ST_PASS:  state_q <= ST_PASS;
                ST_FAIL:  state_q <= ST_FAIL;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign pattern_o  = pat;
    assign pass_o     = (state_q == ST_PASS);
    assign fail_o     = (state_q == ST_FAIL);
    assign done_o     = pass_o || fail_o;
    assign fail_idx_o = idx_q;
endmodule

// File: rtl/bist_sig_ctrl_chk.sv
module bist_sig_ctrl_chk
    import bist_pkg::*;
#(
    parameter int CP_N = 4
) (
    input logic        clk,
    input logic        rst,
    input st_e         state,
    input sig_t        sig,
    input logic [15:0] pattern_o,
    input logic        done_o,
    input logic        pass_o,
    input logic        fail_o,
    input logic [2:0]  fail_idx_o
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state == ST_IDLE && !done_o));

    assert_pattern_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN) |=> $stable(pattern_o));

    assert_sig_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK) |=> $stable(sig));

    assert_single_check_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK) |=> (state != ST_CHECK));

    assert_fail_idx_R6: assert property (@(posedge clk) disable iff (rst)
        fail_o |-> (fail_idx_o >= 3'd1 && fail_idx_o <= 3'(CP_N)));

    assert_pass_idx_R7: assert property (@(posedge clk) disable iff (rst)
        pass_o |-> (fail_idx_o == 3'd0));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (done_o && $stable(pass_o) && $stable(fail_idx_o)));

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(pass_o && fail_o) && ((fail_idx_o != 3'd0) == fail_o));
endmodule

bind bist_sig_ctrl bist_sig_ctrl_chk #(.CP_N(CP_N)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .state      (state_q),
    .sig        (sig),
    .pattern_o  (pattern_o),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .fail_o     (fail_o),
    .fail_idx_o (fail_idx_o)
);

// File: tb/bist_sig_ctrl_tb_top.sv
module bist_sig_ctrl_tb_top;

    localparam int          WIN  = 8;
    localparam logic [15:0] SEED = 16'hACE1;
    localparam logic [15:0] REFV = 16'h3C5A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] cut_resp_i = '0;
    logic [15:0] pattern_o;
    logic        done_o, pass_o, fail_o;
    logic [2:0]  fail_idx_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bist_sig_ctrl #(.WINDOW(WIN), .CP_N(4), .SEED(SEED), .REF(REFV)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .cut_resp_i(cut_resp_i),
        .pattern_o(pattern_o), .done_o(done_o), .pass_o(pass_o),
        .fail_o(fail_o), .fail_idx_o(fail_idx_o)
    );

    function automatic logic [15:0] step16(logic [15:0] s);
        return {s[14:0], 1'b0} ^ (s[15] ? 16'h6801 : 16'h0000);
    endfunction

    function automatic logic [15:0] cut_model(int kind, logic [15:0] p);
        case (kind)
            0:       return p ^ 16'h00FF;
            1:       return {p[7:0], p[15:8]};
            default: return p + 16'h1357;
        endcase
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic session(int kind, int fault_cp, bit hold_start);
        logic [15:0] p, m, r, pat_end;
        bit stopped;
        @(negedge clk);
        rst = 1'b1; start_i = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(pattern_o == SEED, "R1 pattern", pattern_o, SEED);
        chk({done_o, pass_o, fail_o, fail_idx_o} == 6'd0, "R1 flags",
            {done_o, pass_o, fail_o, fail_idx_o}, 0);
        @(negedge clk); @(negedge clk);
        chk(pattern_o == SEED && !done_o, "R1 idle hold", pattern_o, SEED);
        p = SEED; m = '0; stopped = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = hold_start;
        for (int w = 1; w <= 4 && !stopped; w++) begin
            for (int c = 0; c < WIN; c++) begin
                chk(pattern_o == p, "R2 pattern step", pattern_o, p);
                chk(!done_o, "R4 busy in window", done_o, 0);
                r = cut_model(kind, p);
                if (c == WIN - 1) begin
                    r = step16(m) ^ REFV;          // R5 land on shared reference
                    if (w == fault_cp) r = r ^ 16'h0010;
                end
                cut_resp_i = r;
                m = step16(m) ^ r;                 // R3 signature model
                p = step16(p);
                @(negedge clk);
            end
            // check cycle: junk response must not be absorbed (R3)
            cut_resp_i = 16'hFFFF;
            chk(pattern_o == p, "R2 hold in check", pattern_o, p);
            chk(!done_o, "R4 check cycle", done_o, 0);
            @(negedge clk);
            if (w == fault_cp) begin
                chk(fail_o && done_o && !pass_o, "R6 fail flags",
                    {done_o, pass_o, fail_o}, 3'b101);
                chk(fail_idx_o == 3'(w), "R6 fail index", fail_idx_o, w);
                stopped = 1'b1;
            end else if (w == 4) begin
                chk(pass_o && done_o && !fail_o, "R7 pass flags",
                    {done_o, pass_o, fail_o}, 3'b110);
                chk(fail_idx_o == 3'd0, "R7 index zero", fail_idx_o, 0);
            end else begin
                chk(!done_o, "R4 resumed run", done_o, 0);
            end
        end
        // R8 sticky result, start ignored afterwards
        pat_end = pattern_o;
        start_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(done_o && pass_o == (fault_cp == 0) && fail_o == (fault_cp != 0),
                "R8 sticky flags", {done_o, pass_o, fail_o}, 0);
            chk(pattern_o == pat_end, "R8 pattern frozen", pattern_o, pat_end);
            chk(!(pass_o && fail_o) && ((fail_idx_o != 0) == fail_o),
                "R9 exclusive", {pass_o, fail_o, fail_idx_o}, 0);
        end
        start_i = 1'b0;
    endtask

    initial begin
        for (int kind = 0; kind < 3; kind++)
            for (int f = 0; f <= 4; f++)
                session(kind, f, kind == 1);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule